// File: doc/BRIEF.md
# Equalization and Serration Pulse Generator

This block shapes the composite sync stream of a raster timing generator. Outside a programmable band of lines, the composite sync output is the plain OR of the incoming horizontal and vertical sync strobes. Inside the band, normal sync is replaced by narrow equalization pulses on lines where vertical sync is low. On lines where vertical sync is high, it is replaced by broad serration pulses. The pulses repeat either twice per line or once per line, as the mode selects.

The block reads the running pixel and line counters, the line length, two pulse-width values, the first and last line of the band, a 2-bit mode and a disable bit. Its output is active high; polarity is applied further down the chain. The mode values are: 00 interlaced double-rate, 01 non-interlaced double-rate, 11 non-interlaced single-rate. Value 10 is illegal. It is handled as single-rate and leaves a sticky error flag set. Both fields of an interlaced frame get the same treatment, so the field has no effect on the pulses.

Top module: `eqser_sync_gen`

## Requirements
- R1: After reset, `csync` and `mode_err` are both 0.
- R2: `csync` follows the input sampled one clock earlier. When `eqser_dis` is 1, or the line count is outside the band, `csync` equals `hsync_in | vsync_in`.
- R3: The band includes both ends: lines with `band_first <= vcnt <= band_last`.
- R4: In double-rate modes (`mode` 00 and 01), each line has two segments. The first starts at pixel 0 and is `H = line_total >> 1` long. The second starts at pixel H and is `line_total - H` long.
- R5: In single-rate mode (`mode` 11), each line is one segment that starts at pixel 0 and is `line_total` long.
- R6: On a band line with `vsync_in` low, `csync` is 1 exactly when the offset in the segment is below `eq_width`.
- R7: On a band line with `vsync_in` high, `csync` is 1 exactly when the offset in the segment is below `seglen - ser_width`. It stays 0 for the whole segment when `ser_width >= seglen`.
- R8: `mode` 10 gives the same output as `mode` 11. It sets `mode_err` on the next clock, and `mode_err` stays 1 until reset.
- R9: Mode 00 and mode 01 give identical `csync` for identical inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hcnt | input | W | Pixel position within the line |
| vcnt | input | W | Line position within the frame |
| line_total | input | W | Pixels per line |
| mode | input | 2 | Rate/scan mode select |
| eqser_dis | input | 1 | 1 disables pulse replacement |
| eq_width | input | W | Equalization pulse width |
| ser_width | input | W | Serration gap width |
| band_first | input | W | First line of the pulse band |
| band_last | input | W | Last line of the pulse band |
| hsync_in | input | 1 | Normal horizontal sync, active high |
| vsync_in | input | 1 | Vertical sync, active high |
| csync | output | 1 | Composite sync, active high |
| mode_err | output | 1 | Sticky flag: illegal mode seen |

## Verification
The assertions assume that `line_total` is at least 2, that `hcnt` stays below `line_total`, and that `band_first` does not exceed `band_last`. They also assume every input has a defined value from the first clock. The stimulus holds the line length, widths and band fixed while it sweeps every pixel of every line around the band. It uses two line lengths, one even and one odd. All inputs are driven from time zero, so these conditions hold in every cycle the assertions observe.

// File: rtl/eqser_pkg.sv
package eqser_pkg;
   typedef enum logic [1:0] {
      MODE_IL_DBL  = 2'b00,
      MODE_NI_DBL  = 2'b01,
      MODE_BAD     = 2'b10,
      MODE_NI_SGL  = 2'b11
   } eqser_mode_e;

   function automatic logic mode_is_double(input logic [1:0] m);
      return (m == MODE_IL_DBL) || (m == MODE_NI_DBL);
   endfunction
endpackage

// File: rtl/eqser_phase.sv
module eqser_phase #(
   parameter int W = 12
) (
   input  logic [W-1:0] hcnt,
   input  logic [W-1:0] line_total,
   input  logic         dbl,
   output logic [W-1:0] pos,
   output logic [W-1:0] seglen
);
   logic [W-1:0] half;
   logic         upper;

   always_comb begin
      half  = line_total >> 1;
      upper = dbl && (hcnt >= half);
      if (!dbl) begin
         pos    = hcnt;
         seglen = line_total;
      end else if (upper) begin
         pos    = hcnt - half;
         seglen = line_total - half;
      end else begin
         pos    = hcnt;
         seglen = half;
      end
   end
endmodule

// File: rtl/eqser_shape.sv
module eqser_shape #(
   parameter int W = 12
) (
   input  logic [W-1:0] pos,
   input  logic [W-1:0] seglen,
   input  logic [W-1:0] eq_width,
   input  logic [W-1:0] ser_width,
   input  logic         serr,
   output logic         pulse
);
   logic [W-1:0] keep;

   always_comb begin
      keep  = (ser_width >= seglen) ? '0 : (seglen - ser_width);
      pulse = serr ? (pos < keep) : (pos < eq_width);
   end
endmodule

// File: rtl/eqser_band.sv
module eqser_band #(
   parameter int W = 12
) (
   input  logic [W-1:0] vcnt,
   input  logic [W-1:0] band_first,
   input  logic [W-1:0] band_last,
   output logic         in_band
);
   assign in_band = (vcnt >= band_first) && (vcnt <= band_last);
endmodule

// File: rtl/eqser_sync_gen.sv
module eqser_sync_gen
   import eqser_pkg::*;
#(
   parameter int W       = 12,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] hcnt,
   input  logic [W-1:0] vcnt,
   input  logic [W-1:0] line_total,
   input  logic [1:0]   mode,
   input  logic         eqser_dis,
   input  logic [W-1:0] eq_width,
   input  logic [W-1:0] ser_width,
   input  logic [W-1:0] band_first,
   input  logic [W-1:0] band_last,
   input  logic         hsync_in,
   input  logic         vsync_in,
   output logic         csync,
   output logic         mode_err
);
   localparam int MIN_W = 4;

   if (W < MIN_W) begin : g_bad_width
      $error("eqser_sync_gen: W must be at least %0d", MIN_W);
   end

   logic         dbl;
   logic [W-1:0] pos;
   logic [W-1:0] seglen;
   logic         pulse;
   logic         in_band;
   logic         sync_next;
   logic         err_q;

   assign dbl = mode_is_double(mode);

   eqser_phase #(.W(W)) u_phase (
      .hcnt       (hcnt),
      .line_total (line_total),
      .dbl        (dbl),
      .pos        (pos),
      .seglen     (seglen)
   );

   eqser_shape #(.W(W)) u_shape (
      .pos        (pos),
      .seglen     (seglen),
      .eq_width   (eq_width),
      .ser_width  (ser_width),
      .serr       (vsync_in),
      .pulse      (pulse)
   );

   eqser_band #(.W(W)) u_band (
      .vcnt       (vcnt),
      .band_first (band_first),
      .band_last  (band_last),
      .in_band    (in_band)
   );

   always_comb begin
      if (!eqser_dis && in_band) sync_next = pulse;
      else                       sync_next = hsync_in | vsync_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 err_q <= 1'b0;
      else if (mode == MODE_BAD)  err_q <= 1'b1;
   end
   assign mode_err = err_q;

   if (REG_OUT) begin : g_reg_out
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= 1'b0;
         else        sync_q <= sync_next;
      end
      assign csync = sync_q;
   end else begin : g_comb_out
      assign csync = sync_next;
   end
endmodule

// File: rtl/eqser_sync_gen_chk.sv
module eqser_sync_gen_chk #(
   parameter int W       = 12,
   parameter bit REG_OUT = 1'b1
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] vcnt,
   input logic [W-1:0] hcnt,
   input logic [1:0]   mode,
   input logic         eqser_dis,
   input logic [W-1:0] eq_width,
   input logic [W-1:0] band_first,
   input logic [W-1:0] band_last,
   input logic         hsync_in,
   input logic         vsync_in,
   input logic         csync,
   input logic         mode_err
);
   logic seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!csync && !mode_err); // R1
      end
   end

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      seen && mode_err |=> mode_err); // R8

   AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      seen && mode == 2'b10 |=> mode_err); // R8

   if (REG_OUT) begin : g_timed
      AST_DIS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
         seen && eqser_dis |=> csync == ($past(hsync_in) | $past(vsync_in))); // R2

      AST_BELOW_BAND: assert property (@(posedge clk) disable iff (!rst_n)
         seen && vcnt < band_first |=> csync == ($past(hsync_in) | $past(vsync_in))); // R3

      AST_EQ_START: assert property (@(posedge clk) disable iff (!rst_n)
         seen && !eqser_dis && vcnt >= band_first && vcnt <= band_last
         && !vsync_in && hcnt == '0 && eq_width != '0 |=> csync); // R6
   end
endmodule

bind eqser_sync_gen eqser_sync_gen_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .vcnt       (vcnt),
   .hcnt       (hcnt),
   .mode       (mode),
   .eqser_dis  (eqser_dis),
   .eq_width   (eq_width),
   .band_first (band_first),
   .band_last  (band_last),
   .hsync_in   (hsync_in),
   .vsync_in   (vsync_in),
   .csync      (csync),
   .mode_err   (mode_err)
);

// File: tb/eqser_sync_gen_bench.sv
module eqser_sync_gen_bench;
   localparam int W      = 12;
   localparam int TCLK   = 10;
   localparam int BFIRST = 3;
   localparam int BLAST  = 8;
   localparam int EQW    = 3;
   localparam int SERW   = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] hcnt = '0, vcnt = '0, line_total = 12'd40;
   logic [1:0]   mode = 2'b00;
   logic         eqser_dis = 1'b0;
   logic [W-1:0] eq_width = EQW, ser_width = SERW;
   logic [W-1:0] band_first = BFIRST, band_last = BLAST;
   logic         hsync_in = 1'b0, vsync_in = 1'b0;
   logic         csync, mode_err;

   int checks = 0;
   int errors = 0;

   always #(TCLK/2) clk = ~clk;

   eqser_sync_gen #(.W(W)) u_eqser_sync_gen (
      .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt),
      .line_total(line_total), .mode(mode), .eqser_dis(eqser_dis),
      .eq_width(eq_width), .ser_width(ser_width),
      .band_first(band_first), .band_last(band_last),
      .hsync_in(hsync_in), .vsync_in(vsync_in),
      .csync(csync), .mode_err(mode_err)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b (mode=%0b dis=%0b v=%0d h=%0d tot=%0d)",
                  req, act, exp, mode, eqser_dis, vcnt, hcnt, line_total);
      end
   endtask

   function automatic logic model(input int m, input bit dis, input int v,
                                  input int h, input int tot, input bit hs, input bit vs);
      int half, p, sl, keep;
      bit dbl;
      if (dis || v < BFIRST || v > BLAST) return hs | vs;
      dbl  = (m == 0) || (m == 1);
      half = tot / 2;
      if (!dbl)          begin p = h;        sl = tot;        end
      else if (h < half) begin p = h;        sl = half;       end
      else               begin p = h - half; sl = tot - half; end
      keep = (SERW >= sl) ? 0 : sl - SERW;
      return vs ? (p < keep) : (p < EQW);
   endfunction

   function automatic string tag(input int m, input bit dis, input int v, input int tot, input bit vs);
      if (dis || v < BFIRST || v > BLAST) return "R2";
      if (v == BFIRST || v == BLAST)      return "R3";
      if (m == 2)                         return "R8";
      if (m == 3)                         return "R5";
      if (m == 1)                         return "R9";
      if (tot == 41)                      return "R4";
      return vs ? "R7" : "R6";
   endfunction

   task automatic sweep(input int m, input bit dis);
      for (int tot = 40; tot <= 41; tot++) begin
         for (int v = 0; v <= 10; v++) begin
            for (int h = 0; h < tot; h++) begin
               bit hs, vs;
               hs = (h < 5);
               vs = (v >= 4) && (v <= 6);
               @(negedge clk);
               mode = m[1:0]; eqser_dis = dis; line_total = tot[W-1:0];
               vcnt = v[W-1:0]; hcnt = h[W-1:0]; hsync_in = hs; vsync_in = vs;
               @(posedge clk);
               #1;
               check(tag(m, dis, v, tot, vs), csync, model(m, dis, v, h, tot, hs, vs));
            end
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", csync, 1'b0);
      check("R1", mode_err, 1'b0);
      rst_n = 1'b1;
      sweep(0, 1'b0);
      sweep(1, 1'b0);
      sweep(3, 1'b0);
      sweep(0, 1'b1);
      check("R8", mode_err, 1'b0);
      sweep(2, 1'b0);
      check("R8", mode_err, 1'b1);
      sweep(0, 1'b0);
      check("R8", mode_err, 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1", mode_err, 1'b0);
      check("R1", csync, 1'b0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule